// File: doc/BRIEF.md
# Handshaked Subsystem Reset Sequencer

This block takes a single active-low cold reset aimed at a subsystem and distributes it to a parameterized set of sub-blocks. Every sub-block returns a reset acknowledgment. The block combines these into one active-low acknowledgment for the requester. That acknowledgment confirms two things: that reset has reached every included sub-block, and later that the release has reached every included sub-block. The requester can therefore treat both reset entry and reset exit as four-phase handshakes.

The sequencer runs on its own power-on reset, so it stays active while the subsystem it controls is held in reset. A per-block include mask removes absent or disabled sub-blocks from the aggregation. The reset fan-out itself still reaches every sub-block. The block also gates two ready signals, one for a streaming data port and one for a register-access port. Each ready stays low until the exit has finished everywhere.

A watchdog counter raises a sticky error flag if an acknowledgment is late. The handshake keeps waiting after the flag is set.

Top module: `rst_handshake_seq`

## Requirements
- R1: One rising clock edge after `cold_rst_n` falls while the subsystem is running, every bit of `blk_rst_n` is 0.
- R2: `agg_ack_n` falls only after every included sub-block (`blk_mask` bit = 1) has raised its `blk_ack` bit, and never before.
- R3: When `cold_rst_n` rises with the sequencer resting in reset, `blk_rst_n` stays 0 for two rising edges and is all ones after the third.
- R4: `agg_ack_n` rises only after every included sub-block has dropped its `blk_ack` bit.
- R5: `strm_rdy_o` and `csr_rdy_o` are 0 whenever any `blk_rst_n` bit is 0 or `agg_ack_n` is 0. Once the exit has completed, each of them equals its corresponding input.
- R6: A sub-block whose `blk_mask` bit is 0 is left out of both aggregations, whatever its `blk_ack` does.
- R7: If `cold_rst_n` changes while an entry or an exit is waiting for acknowledgments, that phase completes first. Only after it completes is the new level acted on.
- R8: After `TIMEOUT_CYC` consecutive cycles spent waiting in one phase, `timeout_err` goes to 1. It stays 1 until `por_n` is asserted. The handshake still completes once the late acknowledgment arrives.
- R9: While `por_n` is low, and right after it is released, every `blk_rst_n` bit is 0, `agg_ack_n` is 0, both ready outputs are 0 and `timeout_err` is 0.
- R10: All bits of `blk_rst_n` always carry the same value, independent of `blk_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Sequencer's own power-on reset, active low, asynchronous |
| cold_rst_n | input | 1 | Subsystem cold reset request, active low |
| blk_ack | input | N | Per-sub-block reset acknowledgment, asynchronous to `clk` |
| blk_mask | input | N | 1 = sub-block included in aggregation |
| strm_rdy_i | input | 1 | Ready from the streaming data port logic |
| csr_rdy_i | input | 1 | Ready from the register-access port logic |
| blk_rst_n | output | N | Active-low reset to each sub-block |
| agg_ack_n | output | 1 | Aggregate active-low reset acknowledgment |
| strm_rdy_o | output | 1 | Gated streaming ready |
| csr_rdy_o | output | 1 | Gated register-access ready |
| timeout_err | output | 1 | Sticky acknowledgment-timeout flag |

## Verification
The hardest situations to reach are a reversal of `cold_rst_n` in the middle of a phase and the entry of a stale ack into the aggregate. The bench creates the reversal by flipping the request one cycle after a reset entry begins, and again just after the release has reached the sub-blocks. It then checks that the ongoing phase completes before the sequencer reacts. For the stale-ack case, excluded sub-blocks are modelled as stuck at the value that would stall whichever phase would wrongly count them. Every mask pattern is swept with varying per-block ack delays. A further sub-block held silent past the timeout shows that the error flag is sticky while the handshake waits.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    IDLE_RUN       = 2'd0,
    ENTER_WAIT_ACK = 2'd1,
    IN_RESET       = 2'd2,
    EXIT_WAIT_ACK  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rsq_cold_sync.sv
module rsq_cold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic cold_rst_n,
  output logic req_rst
);
  logic             arst_n;
  logic [STAGES-1:0] sync_q;

  assign arst_n = por_n & cold_rst_n;

  // asserted immediately, removed after STAGES edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign req_rst = ~sync_q[STAGES-1];
endmodule

// File: rtl/rsq_ack_agg.sv
module rsq_ack_agg #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [N-1:0] ack_i,
  input  logic [N-1:0] mask_i,
  output logic         all_set,
  output logic         all_clr
);
  logic [N-1:0] ack_s;

  for (genvar i = 0; i < N; i++) begin : g_sync
    logic [STAGES-1:0] stg_q;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], ack_i[i]};
    end
    assign ack_s[i] = stg_q[STAGES-1];
  end

  logic set_d, clr_d;
  assign set_d = &(ack_s | ~mask_i);
  assign clr_d = ~|(ack_s & mask_i);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      all_set <= 1'b0;
      all_clr <= 1'b0;
    end else begin
      all_set <= set_d;
      all_clr <= clr_d;
    end
  end
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
  import rst_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic clk,
  input  logic por_n,
  input  logic req_rst,
  input  logic all_set,
  input  logic all_clr,
  output logic drive_rst,
  output logic ack_asrt,
  output logic run_ok,
  output logic timeout_err
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  seq_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic waiting, cnt_en, err_set;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      IDLE_RUN:       if (req_rst)  state_d = ENTER_WAIT_ACK;
      ENTER_WAIT_ACK: if (all_set)  state_d = IN_RESET;
      IN_RESET:       if (!req_rst) state_d = EXIT_WAIT_ACK;
      EXIT_WAIT_ACK:  if (all_clr)  state_d = IDLE_RUN;
      default:                      state_d = IN_RESET;
    endcase
  end

  assign waiting = (state_q == ENTER_WAIT_ACK) || (state_q == EXIT_WAIT_ACK);
  assign err_set = waiting && (cnt_q == LAST);
  assign cnt_en  = !waiting || (state_d != state_q) || (cnt_q != LAST);

  always_comb begin
    if (!waiting || (state_d != state_q)) cnt_d = '0;
    else                                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q     <= IN_RESET;
      drive_rst   <= 1'b1;
      ack_asrt    <= 1'b1;
      run_ok      <= 1'b0;
      cnt_q       <= '0;
      timeout_err <= 1'b0;
    end else begin
      state_q   <= state_d;
      drive_rst <= (state_d == ENTER_WAIT_ACK) || (state_d == IN_RESET);
      ack_asrt  <= (state_d == IN_RESET) || (state_d == EXIT_WAIT_ACK);
      run_ok    <= (state_d == IDLE_RUN);
      if (cnt_en)  cnt_q       <= cnt_d;
      if (err_set) timeout_err <= 1'b1;
    end
  end
endmodule

// File: rtl/rst_handshake_seq.sv
module rst_handshake_seq #(
  parameter int N           = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         cold_rst_n,
  input  logic [N-1:0] blk_ack,
  input  logic [N-1:0] blk_mask,
  input  logic         strm_rdy_i,
  input  logic         csr_rdy_i,
  output logic [N-1:0] blk_rst_n,
  output logic         agg_ack_n,
  output logic         strm_rdy_o,
  output logic         csr_rdy_o,
  output logic         timeout_err
);
  logic req_rst, all_set, all_clr, drive_rst, ack_asrt, run_ok;

  rsq_cold_sync #(.STAGES(SYNC_STAGES)) u_cold (
    .clk(clk), .por_n(por_n), .cold_rst_n(cold_rst_n), .req_rst(req_rst)
  );

  rsq_ack_agg #(.N(N), .STAGES(SYNC_STAGES)) u_agg (
    .clk(clk), .por_n(por_n), .ack_i(blk_ack), .mask_i(blk_mask),
    .all_set(all_set), .all_clr(all_clr)
  );

  rsq_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk(clk), .por_n(por_n), .req_rst(req_rst), .all_set(all_set),
    .all_clr(all_clr), .drive_rst(drive_rst), .ack_asrt(ack_asrt),
    .run_ok(run_ok), .timeout_err(timeout_err)
  );

  assign blk_rst_n  = {N{~drive_rst}};
  assign agg_ack_n  = ~ack_asrt;
  assign strm_rdy_o = strm_rdy_i & run_ok;
  assign csr_rdy_o  = csr_rdy_i & run_ok;
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         por_n,
  input logic [N-1:0] blk_ack,
  input logic [N-1:0] blk_mask,
  input logic [N-1:0] blk_rst_n,
  input logic         agg_ack_n,
  input logic         strm_rdy_o,
  input logic         csr_rdy_o,
  input logic         timeout_err
);
  // R2
  entry_full_ack_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(agg_ack_n) |-> &(blk_ack | ~blk_mask));

  // R4
  exit_full_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(agg_ack_n) |-> ~|(blk_ack & blk_mask));

  // R5
  ready_gated_chk: assert property (@(posedge clk) disable iff (!por_n)
    ((blk_rst_n != '1) || !agg_ack_n) |-> (!strm_rdy_o && !csr_rdy_o));

  // R10
  fanout_uniform_chk: assert property (@(posedge clk) disable iff (!por_n)
    (blk_rst_n == '0) || (blk_rst_n == '1));

  // R7
  release_after_ack_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(blk_rst_n[0]) |-> !agg_ack_n);

  // R7
  entry_from_run_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(blk_rst_n[0]) |-> agg_ack_n);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    timeout_err |=> timeout_err);
endmodule

bind rst_handshake_seq rsq_chk #(.N(N)) u_chk (
  .clk(clk), .por_n(por_n), .blk_ack(blk_ack), .blk_mask(blk_mask),
  .blk_rst_n(blk_rst_n), .agg_ack_n(agg_ack_n), .strm_rdy_o(strm_rdy_o),
  .csr_rdy_o(csr_rdy_o), .timeout_err(timeout_err)
);

// File: tb/sim_rst_handshake_seq.sv
module sim_rst_handshake_seq;
  localparam int N  = 4;
  localparam int TO = 40;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic cold_rst_n = 1'b0;
  logic [N-1:0] blk_ack = '0;
  logic [N-1:0] blk_mask = '1;
  logic strm_rdy_i = 1'b1, csr_rdy_i = 1'b1;
  logic [N-1:0] blk_rst_n;
  logic agg_ack_n, strm_rdy_o, csr_rdy_o, timeout_err;

  logic [N-1:0] stuck = '0, stuck_val = '0;
  int dly [N];
  int mcnt [N];
  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rst_handshake_seq #(.N(N), .SYNC_STAGES(2), .TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .por_n(por_n), .cold_rst_n(cold_rst_n), .blk_ack(blk_ack),
    .blk_mask(blk_mask), .strm_rdy_i(strm_rdy_i), .csr_rdy_i(csr_rdy_i),
    .blk_rst_n(blk_rst_n), .agg_ack_n(agg_ack_n), .strm_rdy_o(strm_rdy_o),
    .csr_rdy_o(csr_rdy_o), .timeout_err(timeout_err)
  );

  // sub-block model: ack follows inverted reset after dly cycles
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (stuck[i]) begin
        blk_ack[i] <= stuck_val[i];
        mcnt[i]    <= 0;
      end else if (blk_ack[i] == blk_rst_n[i]) begin
        if (mcnt[i] + 1 >= dly[i]) begin
          blk_ack[i] <= ~blk_rst_n[i];
          mcnt[i]    <= 0;
        end else mcnt[i] <= mcnt[i] + 1;
      end else mcnt[i] <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic wait_agg(input logic val, input int lim, output bit hit);
    hit = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (agg_ack_n == val) begin hit = 1; return; end
    end
  endtask

  function automatic bit inc_all_high();
    return &(blk_ack | ~blk_mask);
  endfunction
  function automatic bit inc_all_low();
    return ~|(blk_ack & blk_mask);
  endfunction

  task automatic do_entry();
    bit hit;
    cold_rst_n = 1'b0;
    @(negedge clk);
    chk(blk_rst_n == '0, "R1", blk_rst_n, 0);
    chk(blk_rst_n == '0 || blk_rst_n == '1, "R10", blk_rst_n, 0);
    chk(!strm_rdy_o && !csr_rdy_o, "R5", {strm_rdy_o, csr_rdy_o}, 0);
    wait_agg(1'b0, 60, hit);
    chk(hit, "R2 entry completes", agg_ack_n, 0);
    chk(inc_all_high(), "R2 acks at fall", blk_ack, blk_mask);
  endtask

  task automatic do_exit(input bit masked);
    bit hit;
    cold_rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(blk_rst_n == '0, "R3 held", blk_rst_n, 0);
    @(negedge clk);
    chk(blk_rst_n == '1, "R3 released", blk_rst_n, '1);
    chk(!strm_rdy_o && !csr_rdy_o, "R5 exit", {strm_rdy_o, csr_rdy_o}, 0);
    wait_agg(1'b1, 60, hit);
    chk(hit, masked ? "R6 exit completes" : "R4 exit completes", agg_ack_n, 1);
    chk(inc_all_low(), "R4 acks at rise", blk_ack, 0);
    @(negedge clk);
    chk(strm_rdy_o == strm_rdy_i && csr_rdy_o == csr_rdy_i, "R5 pass",
        {strm_rdy_o, csr_rdy_o}, {strm_rdy_i, csr_rdy_i});
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(0, "watchdog", cyc, 0);
        finish_run();
      end
    end
  end

  initial begin
    bit hit;
    for (int i = 0; i < N; i++) begin dly[i] = i + 2; mcnt[i] = 0; end
    repeat (3) @(negedge clk);
    // R9 during and after power-on reset
    chk(blk_rst_n == '0 && agg_ack_n == 1'b0, "R9 in por", {blk_rst_n, agg_ack_n}, 0);
    por_n = 1'b1;
    @(negedge clk);
    chk(blk_rst_n == '0, "R9 rst", blk_rst_n, 0);
    chk(agg_ack_n == 1'b0, "R9 ack", agg_ack_n, 0);
    chk(!strm_rdy_o && !csr_rdy_o, "R9 ready", {strm_rdy_o, csr_rdy_o}, 0);
    chk(!timeout_err, "R9 err", timeout_err, 0);
    repeat (20) @(negedge clk);
    do_exit(0);

    // sweep every include mask; excluded blocks stuck at a stalling value
    for (int m = 0; m < (1 << N); m++) begin
      blk_mask = N'(m);
      for (int i = 0; i < N; i++) begin
        dly[i]       = ((i * 5 + m * 3) % 7) + 1;
        stuck[i]     = ~blk_mask[i];
        stuck_val[i] = i[0];
      end
      repeat (12) @(negedge clk);
      do_entry();
      do_exit(blk_mask != '1);
    end
    stuck = '0;
    blk_mask = '1;
    chk(!timeout_err, "R8 no error on timely acks", timeout_err, 0);

    // ready pass-through with one input low
    csr_rdy_i = 1'b0;
    repeat (10) @(negedge clk);
    chk(csr_rdy_o == 1'b0 && strm_rdy_o == 1'b1, "R5 independent", {strm_rdy_o, csr_rdy_o}, 2'b10);
    csr_rdy_i = 1'b1;

    // R7: release during entry wait
    for (int i = 0; i < N; i++) dly[i] = 6;
    cold_rst_n = 1'b0;
    @(negedge clk);
    cold_rst_n = 1'b1;
    hit = 0;
    for (int k = 0; k < 60 && !hit; k++) begin
      @(negedge clk);
      if (agg_ack_n == 1'b0) hit = 1;
      else chk(blk_rst_n == '0, "R7 entry finishes", blk_rst_n, 0);
    end
    chk(hit, "R7 entry ack", agg_ack_n, 0);
    chk(blk_rst_n == '0, "R7 still in reset at ack", blk_rst_n, 0);
    wait_agg(1'b1, 60, hit);
    chk(hit && blk_rst_n == '1, "R7 exit follows", {blk_rst_n, agg_ack_n}, {4'hf, 1'b1});

    // R7: reassert during exit wait
    do_entry();
    cold_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(blk_rst_n == '1, "R3 before reversal", blk_rst_n, '1);
    cold_rst_n = 1'b0;
    hit = 0;
    for (int k = 0; k < 60 && !hit; k++) begin
      @(negedge clk);
      if (agg_ack_n == 1'b1) hit = 1;
      else chk(blk_rst_n == '1, "R7 exit finishes", blk_rst_n, '1);
    end
    chk(hit, "R7 exit ack", agg_ack_n, 1);
    repeat (3) @(negedge clk);
    chk(blk_rst_n == '0, "R7 re-entry", blk_rst_n, 0);
    wait_agg(1'b0, 60, hit);
    chk(hit, "R7 re-entry ack", agg_ack_n, 0);
    do_exit(0);

    // R8: one silent block during entry
    stuck[2] = 1'b1; stuck_val[2] = 1'b0;
    repeat (5) @(negedge clk);
    cold_rst_n = 1'b0;
    repeat (TO - 8) @(negedge clk);
    chk(!timeout_err, "R8 early", timeout_err, 0);
    repeat (20) @(negedge clk);
    chk(timeout_err, "R8 flagged", timeout_err, 1);
    chk(agg_ack_n == 1'b1, "R8 still waiting", agg_ack_n, 1);
    stuck[2] = 1'b0;
    wait_agg(1'b0, 60, hit);
    chk(hit, "R8 handshake completes", agg_ack_n, 0);
    chk(timeout_err, "R8 sticky", timeout_err, 1);
    do_exit(0);
    chk(timeout_err, "R8 sticky after exit", timeout_err, 1);

    finish_run();
  end
endmodule